// File: doc/BRIEF.md
# Extremum-Seeking Deadtime Vertex Adapter

This block tunes, while the converter runs, the vertices of two piecewise-linear deadtime curves (synchronous-rectifier turn-on deadtime and turn-off deadtime versus load current) so that measured power loss falls. It produces two square-wave dither bits, one per curve. The surrounding logic adds each bit to the matching scheduled deadtime. The fast dither drives the turn-off curve and the slow dither the turn-on curve. Both advance only on a loss-sample strobe. Their periods are in a 1:2 ratio, so over one slow period each is orthogonal to the other and to a constant.

On each valid sample the block adds the loss value into a per-curve gradient accumulator. The value is added when that curve's dither bit is high and subtracted when it is low. Once a window of whole slow-dither periods is complete, the block computes new values for the two vertices that bracket the present load current. The lower vertex moves against the gradient weighted by (1 − alpha), and the upper vertex weighted by alpha. The gain is a right shift. The results are clamped to the legal deadtime range, plus a floor on the turn-on curve at light load. They leave as a one-cycle write command to the external vertex store, and the accumulators then clear. The store supplies the current values of the bracketing vertices on the read inputs during the sample that closes the window.

Top module: `esc_vertex_adapt`

## Requirements
- R1: After a synchronous active-low reset, both dither bits are high, the write strobe is low and the dither phase and window counters are at zero.
- R2: The dither phase advances once per valid sample over a period of 4·HALF samples. The turn-off dither (fast) is high for phases [0,HALF) and [2·HALF,3·HALF), and low otherwise. The turn-on dither (slow) is high for phases [0,2·HALF). The slow bit changes only in a cycle in which the fast bit rises.
- R3: Each curve's gradient is the sum, over a window of WIN_PERIODS·4·HALF valid samples, of +loss when that curve's dither bit is high at the sample and −loss when it is low. The sum restarts from zero after each window.
- R4: The cycle after the sample that closes a window, wr_en is high for exactly one cycle. wr_idx then holds the bracketing index presented with that sample, and the new values are computed from the alpha and vertex read values presented with that sample.
- R5: With alpha in units of 1/2^ALPHA_W and g the gradient, the new lower vertex is v_lo − floor((2^ALPHA_W − alpha)·g / 2^(ALPHA_W+GAIN_SH)). The new upper vertex is v_hi − floor(alpha·g / 2^(ALPHA_W+GAIN_SH)). All other vertices receive no write.
- R6: Every written vertex value is clamped to [DT_MIN, DT_MAX].
- R7: For the turn-on curve, a vertex whose index is below lim_on_idx is clamped to at least lim_on_floor. The turn-off curve has no such floor.
- R8: wr_hi_en is high with wr_en only when wr_idx is below NVERT−1. At the top index the upper vertex is not written.
- R9: Cycles without the sample strobe leave the dither bits, the phase, the window progress and the accumulated gradient unchanged, whatever the loss input carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_vld | input | 1 | Loss sample strobe |
| loss | input | LOSS_W | Power-loss sample, unsigned |
| seg_idx | input | IDX_W | Index of the lower bracketing vertex |
| alpha | input | ALPHA_W | Fractional position of the load current between the vertices |
| rd_on_lo | input | DT_W | Turn-on curve, current value of vertex seg_idx |
| rd_on_hi | input | DT_W | Turn-on curve, current value of vertex seg_idx+1 |
| rd_off_lo | input | DT_W | Turn-off curve, current value of vertex seg_idx |
| rd_off_hi | input | DT_W | Turn-off curve, current value of vertex seg_idx+1 |
| lim_on_idx | input | IDX_W | Vertices of the turn-on curve below this index take the floor |
| lim_on_floor | input | DT_W | Light-load floor for the turn-on curve |
| dith_on | output | 1 | Slow dither bit for the turn-on deadtime |
| dith_off | output | 1 | Fast dither bit for the turn-off deadtime |
| wr_en | output | 1 | Write strobe for the lower vertex of both curves |
| wr_hi_en | output | 1 | Write strobe for the upper vertex of both curves |
| wr_idx | output | IDX_W | Lower vertex index of the write |
| wr_on_lo | output | DT_W | New turn-on value, lower vertex |
| wr_on_hi | output | DT_W | New turn-on value, upper vertex |
| wr_off_lo | output | DT_W | New turn-off value, lower vertex |
| wr_off_hi | output | DT_W | New turn-off value, upper vertex |

## Verification
The closing sample of a window does three things in one cycle. It adds its own term to both gradients, it wraps both dithers back to their high phase, and it launches the write that uses the completed sum. A slip by one sample in any of these shows up as a wrong vertex value or a misplaced dither edge. The bench drives back-to-back windows, with and without idle gaps and with loss varying during idle cycles. Its behavioural model produces the expected dither bits, strobe and written values on every clock, so a gradient that drops or double-counts the closing sample, or a write one cycle early or late, fails the comparison in that cycle.

// File: rtl/esc_pkg.sv
// Shared definitions for the extremum-seeking vertex adapter.
// Assumes two curves only: turn-on deadtime (slow dither) and turn-off (fast).
package esc_pkg;
    typedef enum logic {CRV_ON = 1'b0, CRV_OFF = 1'b1} crv_e;
    localparam int NCRV = 2;
endpackage

// File: rtl/esc_dither_gen.sv
// Dither and window sequencer.
// Produces the two square-wave dither bits from one phase counter that
// advances per valid sample, and flags the sample that closes a window.
// Assumes HALF >= 1 and WIN_PERIODS >= 1.
module esc_dither_gen #(
    parameter int HALF        = 2,
    parameter int WIN_PERIODS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_vld,
    output logic dith_slow,
    output logic dith_fast,
    output logic close
);
    localparam int PER  = 4 * HALF;
    localparam int PH_W = (PER > 1) ? $clog2(PER) : 1;
    localparam int WC_W = (WIN_PERIODS > 1) ? $clog2(WIN_PERIODS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PER - 1);
    localparam logic [WC_W-1:0] WC_LAST = WC_W'(WIN_PERIODS - 1);

    logic [PH_W-1:0] ph;
    logic [WC_W-1:0] wcnt;
    logic            ph_wrap;

    // Decode dither levels from the phase counter.
    always_comb begin
        dith_slow = (32'(ph) < 2 * HALF);
        dith_fast = (32'(ph) < HALF) ||
                    ((32'(ph) >= 2 * HALF) && (32'(ph) < 3 * HALF));
        ph_wrap   = (ph == PH_LAST);
        close     = s_vld && ph_wrap && (wcnt == WC_LAST);
    end

    // Advance phase and window counters on each valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph   <= '0;
            wcnt <= '0;
        end else if (s_vld) begin
            if (ph_wrap) begin
                ph   <= '0;
                wcnt <= (wcnt == WC_LAST) ? '0 : wcnt + 1'b1;
            end else begin
                ph   <= ph + 1'b1;
            end
        end
    end
endmodule

// File: rtl/esc_correlator.sv
// Gradient accumulator for one curve.
// Adds +loss or -loss per valid sample by dither level. grad_nxt carries
// the sum including the current sample so the closing sample is counted.
module esc_correlator #(
    parameter int LOSS_W = 12,
    parameter int ACC_W  = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s_vld,
    input  logic                    close,
    input  logic                    dith,
    input  logic [LOSS_W-1:0]       loss,
    output logic signed [ACC_W-1:0] grad_nxt
);
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] term;

    // Signed product of loss and dither sign.
    always_comb begin
        term     = $signed({{(ACC_W-LOSS_W){1'b0}}, loss});
        if (!dith) term = -term;
        grad_nxt = acc + term;
    end

    // Integrate on valid samples and clear at window close.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc <= '0;
        else if (s_vld)  acc <= close ? '0 : grad_nxt;
    end
endmodule

// File: rtl/esc_vertex_step.sv
// One vertex update: v - floor(w*g / 2^SH), clamped to [lb, DT_MAX].
// Assumes lb <= DT_MAX is the caller's choice; lb wins if it is not.
module esc_vertex_step #(
    parameter int DT_W    = 8,
    parameter int W_W     = 5,
    parameter int ACC_W   = 18,
    parameter int SH      = 10,
    parameter int DT_MAX  = 200
) (
    input  logic [DT_W-1:0]         v,
    input  logic [W_W-1:0]          w,
    input  logic signed [ACC_W-1:0] g,
    input  logic [DT_W-1:0]         lb,
    output logic [DT_W-1:0]         v_new
);
    localparam int PW = ACC_W + W_W + 2;
    localparam logic signed [PW-1:0] MAXV = PW'(DT_MAX);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] step;
    logic signed [PW-1:0] cand;
    logic signed [PW-1:0] lbv;

    // Weighted step, floor by arithmetic shift, then saturate.
    always_comb begin
        prod  = $signed({{(PW-W_W){1'b0}}, w}) * $signed({{(PW-ACC_W){g[ACC_W-1]}}, g});
        step  = prod >>> SH;
        cand  = $signed({{(PW-DT_W){1'b0}}, v}) - step;
        lbv   = $signed({{(PW-DT_W){1'b0}}, lb});
        if (cand > MAXV) cand = MAXV;
        if (cand < lbv)  cand = lbv;
        v_new = cand[DT_W-1:0];
    end
endmodule

// File: rtl/esc_vertex_adapt.sv
// Extremum-seeking adapter for two deadtime curves.
// Generates dithers, correlates loss per curve and issues registered vertex
// writes one cycle after each window closes. Assumes the vertex store
// presents the bracketing vertex values on rd_* during the closing sample.
module esc_vertex_adapt
    import esc_pkg::*;
#(
    parameter int DT_W        = 8,
    parameter int LOSS_W      = 12,
    parameter int ALPHA_W     = 4,
    parameter int IDX_W       = 3,
    parameter int NVERT       = 7,
    parameter int HALF        = 2,
    parameter int WIN_PERIODS = 2,
    parameter int GAIN_SH     = 6,
    parameter int DT_MIN      = 1,
    parameter int DT_MAX      = 200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_vld,
    input  logic [LOSS_W-1:0]  loss,
    input  logic [IDX_W-1:0]   seg_idx,
    input  logic [ALPHA_W-1:0] alpha,
    input  logic [DT_W-1:0]    rd_on_lo,
    input  logic [DT_W-1:0]    rd_on_hi,
    input  logic [DT_W-1:0]    rd_off_lo,
    input  logic [DT_W-1:0]    rd_off_hi,
    input  logic [IDX_W-1:0]   lim_on_idx,
    input  logic [DT_W-1:0]    lim_on_floor,
    output logic               dith_on,
    output logic               dith_off,
    output logic               wr_en,
    output logic               wr_hi_en,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [DT_W-1:0]    wr_on_lo,
    output logic [DT_W-1:0]    wr_on_hi,
    output logic [DT_W-1:0]    wr_off_lo,
    output logic [DT_W-1:0]    wr_off_hi
);
    localparam int WIN   = WIN_PERIODS * 4 * HALF;
    localparam int ACC_W = LOSS_W + $clog2(WIN + 1) + 2;
    localparam int W_W   = ALPHA_W + 1;
    localparam int SH    = ALPHA_W + GAIN_SH;
    localparam logic [DT_W-1:0] DTMIN_V = DT_W'(DT_MIN);

    logic                    close;
    logic [NCRV-1:0]         dith;
    logic signed [ACC_W-1:0] grad   [NCRV];
    logic [DT_W-1:0]         v_lo   [NCRV];
    logic [DT_W-1:0]         v_hi   [NCRV];
    logic [DT_W-1:0]         lb_lo  [NCRV];
    logic [DT_W-1:0]         lb_hi  [NCRV];
    logic [DT_W-1:0]         n_lo   [NCRV];
    logic [DT_W-1:0]         n_hi   [NCRV];
    logic [W_W-1:0]          w_lo;
    logic [W_W-1:0]          w_hi;
    logic [DT_W-1:0]         flr;
    logic [IDX_W:0]          idx_up;

    esc_dither_gen #(.HALF(HALF), .WIN_PERIODS(WIN_PERIODS)) u_dith (
        .clk(clk), .rst_n(rst_n), .s_vld(s_vld),
        .dith_slow(dith[CRV_ON]), .dith_fast(dith[CRV_OFF]), .close(close)
    );

    // Interpolation weights and per-curve bounds for both bracketing vertices.
    always_comb begin
        w_hi   = {1'b0, alpha};
        w_lo   = W_W'(1 << ALPHA_W) - w_hi;
        flr    = (lim_on_floor > DTMIN_V) ? lim_on_floor : DTMIN_V;
        idx_up = {1'b0, seg_idx} + 1'b1;
        v_lo[CRV_ON]   = rd_on_lo;
        v_hi[CRV_ON]   = rd_on_hi;
        v_lo[CRV_OFF]  = rd_off_lo;
        v_hi[CRV_OFF]  = rd_off_hi;
        lb_lo[CRV_ON]  = (seg_idx < lim_on_idx) ? flr : DTMIN_V;
        lb_hi[CRV_ON]  = (idx_up < {1'b0, lim_on_idx}) ? flr : DTMIN_V;
        lb_lo[CRV_OFF] = DTMIN_V;
        lb_hi[CRV_OFF] = DTMIN_V;
    end

    for (genvar c = 0; c < NCRV; c++) begin : g_crv
        esc_correlator #(.LOSS_W(LOSS_W), .ACC_W(ACC_W)) u_corr (
            .clk(clk), .rst_n(rst_n), .s_vld(s_vld), .close(close),
            .dith(dith[c]), .loss(loss), .grad_nxt(grad[c])
        );
        esc_vertex_step #(.DT_W(DT_W), .W_W(W_W), .ACC_W(ACC_W), .SH(SH),
                          .DT_MAX(DT_MAX)) u_lo (
            .v(v_lo[c]), .w(w_lo), .g(grad[c]), .lb(lb_lo[c]), .v_new(n_lo[c])
        );
        esc_vertex_step #(.DT_W(DT_W), .W_W(W_W), .ACC_W(ACC_W), .SH(SH),
                          .DT_MAX(DT_MAX)) u_hi (
            .v(v_hi[c]), .w(w_hi), .g(grad[c]), .lb(lb_hi[c]), .v_new(n_hi[c])
        );
    end

    assign dith_on  = dith[CRV_ON];
    assign dith_off = dith[CRV_OFF];

    // Register the write command for one cycle after the closing sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en     <= 1'b0;
            wr_hi_en  <= 1'b0;
            wr_idx    <= '0;
            wr_on_lo  <= '0;
            wr_on_hi  <= '0;
            wr_off_lo <= '0;
            wr_off_hi <= '0;
        end else begin
            wr_en    <= close;
            wr_hi_en <= close && (32'(seg_idx) < NVERT - 1);
            if (close) begin
                wr_idx    <= seg_idx;
                wr_on_lo  <= n_lo[CRV_ON];
                wr_on_hi  <= n_hi[CRV_ON];
                wr_off_lo <= n_lo[CRV_OFF];
                wr_off_hi <= n_hi[CRV_OFF];
            end
        end
    end
endmodule

// File: rtl/esc_vertex_adapt_chk.sv
// Property checker for esc_vertex_adapt, bound to every instance.
module esc_vertex_adapt_chk #(
    parameter int DT_W   = 8,
    parameter int IDX_W  = 3,
    parameter int NVERT  = 7,
    parameter int DT_MIN = 1,
    parameter int DT_MAX = 200
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_vld,
    input logic             dith_on,
    input logic             dith_off,
    input logic             wr_en,
    input logic             wr_hi_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [DT_W-1:0]  wr_on_lo,
    input logic [DT_W-1:0]  wr_on_hi,
    input logic [DT_W-1:0]  wr_off_lo,
    input logic [DT_W-1:0]  wr_off_hi,
    input logic [IDX_W-1:0] lim_on_idx,
    input logic [DT_W-1:0]  lim_on_floor
);
    // R9: idle cycles leave both dithers in place.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !s_vld |=> ($stable(dith_on) && $stable(dith_off)));

    // R2: the slow dither changes only together with a rising fast dither.
    p_slow_on_fast_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dith_on != $past(dith_on)) |-> $rose(dith_off));

    // R4: the write strobe lasts one cycle.
    p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R6: written values stay inside the legal range.
    p_wr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_on_lo <= DT_W'(DT_MAX) && wr_off_lo <= DT_W'(DT_MAX) &&
                   wr_on_hi <= DT_W'(DT_MAX) && wr_off_hi <= DT_W'(DT_MAX) &&
                   wr_on_lo >= DT_W'(DT_MIN) && wr_off_lo >= DT_W'(DT_MIN) &&
                   wr_on_hi >= DT_W'(DT_MIN) && wr_off_hi >= DT_W'(DT_MIN)));

    // R7: turn-on lower vertex below the limit index respects the floor.
    p_on_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx < $past(lim_on_idx))) |-> (wr_on_lo >= $past(lim_on_floor)));

    // R8: no upper write at the top vertex, and never without the lower write.
    p_top_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi_en |-> (wr_en && (32'(wr_idx) < NVERT - 1)));
endmodule

bind esc_vertex_adapt esc_vertex_adapt_chk #(
    .DT_W(DT_W), .IDX_W(IDX_W), .NVERT(NVERT), .DT_MIN(DT_MIN), .DT_MAX(DT_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .s_vld(s_vld), .dith_on(dith_on),
    .dith_off(dith_off), .wr_en(wr_en), .wr_hi_en(wr_hi_en), .wr_idx(wr_idx),
    .wr_on_lo(wr_on_lo), .wr_on_hi(wr_on_hi), .wr_off_lo(wr_off_lo),
    .wr_off_hi(wr_off_hi), .lim_on_idx(lim_on_idx), .lim_on_floor(lim_on_floor)
);

// File: tb/esc_vertex_adapt_bench.sv
// Bench: behavioural reference model stepped on every rising edge and
// compared against the outputs on every falling edge.
module esc_vertex_adapt_bench;
    localparam int DT_W = 8, LOSS_W = 12, ALPHA_W = 4, IDX_W = 3, NVERT = 7;
    localparam int HALF = 2, WIN_PERIODS = 2, GAIN_SH = 6;
    localparam int DT_MIN = 1, DT_MAX = 200;
    localparam int PER = 4 * HALF, WIN = PER * WIN_PERIODS;

    logic clk = 1'b0, rst_n = 1'b0, s_vld = 1'b0;
    logic [LOSS_W-1:0]  loss = '0;
    logic [IDX_W-1:0]   seg_idx = '0, lim_on_idx = '0;
    logic [ALPHA_W-1:0] alpha = '0;
    logic [DT_W-1:0]    rd_on_lo = 8'd100, rd_on_hi = 8'd120;
    logic [DT_W-1:0]    rd_off_lo = 8'd50, rd_off_hi = 8'd60, lim_on_floor = '0;
    logic dith_on, dith_off, wr_en, wr_hi_en;
    logic [IDX_W-1:0] wr_idx;
    logic [DT_W-1:0]  wr_on_lo, wr_on_hi, wr_off_lo, wr_off_hi;

    always #2 clk = ~clk;

    esc_vertex_adapt #(
        .DT_W(DT_W), .LOSS_W(LOSS_W), .ALPHA_W(ALPHA_W), .IDX_W(IDX_W),
        .NVERT(NVERT), .HALF(HALF), .WIN_PERIODS(WIN_PERIODS),
        .GAIN_SH(GAIN_SH), .DT_MIN(DT_MIN), .DT_MAX(DT_MAX)
    ) u_esc_vertex_adapt (
        .clk(clk), .rst_n(rst_n), .s_vld(s_vld), .loss(loss), .seg_idx(seg_idx),
        .alpha(alpha), .rd_on_lo(rd_on_lo), .rd_on_hi(rd_on_hi),
        .rd_off_lo(rd_off_lo), .rd_off_hi(rd_off_hi), .lim_on_idx(lim_on_idx),
        .lim_on_floor(lim_on_floor), .dith_on(dith_on), .dith_off(dith_off),
        .wr_en(wr_en), .wr_hi_en(wr_hi_en), .wr_idx(wr_idx),
        .wr_on_lo(wr_on_lo), .wr_on_hi(wr_on_hi), .wr_off_lo(wr_off_lo),
        .wr_off_hi(wr_off_hi)
    );

    int n_chk = 0, n_bad = 0, n_wr = 0;

    // Reference model state.
    int m_ph = 0, m_cnt = 0, m_acc_on = 0, m_acc_off = 0;
    int e_on_lo = 0, e_on_hi = 0, e_off_lo = 0, e_off_hi = 0, e_idx = 0;
    bit e_wr = 0, e_hi = 0;

    function automatic bit m_slow(int p); return p < 2 * HALF; endfunction
    function automatic bit m_fast(int p); return (p % (2 * HALF)) < HALF; endfunction

    function automatic int fdiv(int num, int den);
        if (num >= 0) return num / den;
        return -((-num + den - 1) / den);
    endfunction

    function automatic int upd(int v, int w, int g, int lb);
        int n;
        n = v - fdiv(w * g, 1 << (ALPHA_W + GAIN_SH));
        if (n > DT_MAX) n = DT_MAX;
        if (n < lb) n = lb;
        return n;
    endfunction

    function automatic int on_lb(int k);
        int f;
        f = (int'(lim_on_floor) > DT_MIN) ? int'(lim_on_floor) : DT_MIN;
        return (k < int'(lim_on_idx)) ? f : DT_MIN;
    endfunction

    // Model step at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_acc_on = 0; m_acc_off = 0; e_wr = 0; e_hi = 0;
        end else begin
            e_wr = 0; e_hi = 0;
            if (s_vld) begin
                m_acc_on  += m_slow(m_ph) ? int'(loss) : -int'(loss);
                m_acc_off += m_fast(m_ph) ? int'(loss) : -int'(loss);
                m_cnt++;
                m_ph = (m_ph + 1) % PER;
                if (m_cnt == WIN) begin
                    e_wr = 1;
                    e_idx = int'(seg_idx);
                    e_hi = e_idx < NVERT - 1;
                    e_on_lo  = upd(rd_on_lo,  16 - int'(alpha), m_acc_on,  on_lb(e_idx));
                    e_on_hi  = upd(rd_on_hi,  int'(alpha),      m_acc_on,  on_lb(e_idx + 1));
                    e_off_lo = upd(rd_off_lo, 16 - int'(alpha), m_acc_off, DT_MIN);
                    e_off_hi = upd(rd_off_hi, int'(alpha),      m_acc_off, DT_MIN);
                    m_cnt = 0; m_acc_on = 0; m_acc_off = 0;
                end
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare on every falling edge once out of reset.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 dith_on",  dith_on,  m_slow(m_ph));
            chk("R2 dith_off", dith_off, m_fast(m_ph));
            chk("R4 wr_en",    wr_en,    e_wr);
            if (e_wr) begin
                n_wr++;
                chk("R4 wr_idx",     wr_idx,    e_idx);
                chk("R8 wr_hi_en",   wr_hi_en,  e_hi);
                chk("R5 wr_on_lo",   wr_on_lo,  e_on_lo);
                chk("R5 wr_off_lo",  wr_off_lo, e_off_lo);
                if (e_hi) begin
                    chk("R5 wr_on_hi",  wr_on_hi,  e_on_hi);
                    chk("R5 wr_off_hi", wr_off_hi, e_off_hi);
                end
            end else begin
                chk("R8 wr_hi_en idle", wr_hi_en, 0);
            end
        end
    end

    // One window of samples; loss follows the dither seen at the ports.
    task automatic run_win(int idx, int al, int base, int a_on, int a_off, bit gaps);
        for (int n = 0; n < WIN; n++) begin
            int l;
            @(negedge clk);
            l = base + (dith_on ? a_on : 0) + (dith_off ? a_off : 0);
            if (l < 0) l = 0;
            if (l > 4095) l = 4095;
            s_vld = 1'b1; loss = LOSS_W'(l);
            seg_idx = IDX_W'(idx); alpha = ALPHA_W'(al);
            if (gaps) begin
                @(negedge clk);
                s_vld = 1'b0; loss = LOSS_W'(4095 - l); // R9 noise while idle
                @(negedge clk);
            end
        end
        @(negedge clk);
        s_vld = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 dith_on", dith_on, 1);
        chk("R1 dith_off", dith_off, 1);
        chk("R1 wr_en", wr_en, 0);
        // R3 R5: positive on-correlation, mid alpha
        run_win(2, 5, 1000, 400, 0, 0);
        chk("R5 on lower moves down", int'(wr_on_lo) < 100, 1);
        // R3 R9: negative off-correlation with idle gaps
        run_win(3, 9, 2000, 0, -300, 1);
        chk("R5 off lower moves up", int'(wr_off_lo) > 50, 1);
        // R5: alpha extremes
        run_win(1, 0, 500, -200, 150, 0);
        run_win(4, 15, 500, 250, -150, 1);
        // R8: top index
        run_win(6, 7, 800, 300, 300, 0);
        chk("R8 no upper at top", wr_hi_en, 0);
        // R6: saturation both ways
        rd_on_lo = 8'd199; rd_off_lo = 8'd2; rd_on_hi = 8'd2; rd_off_hi = 8'd199;
        run_win(2, 8, 2000, -2000, 2000, 0);
        chk("R6 on_lo clamp max", wr_on_lo, DT_MAX);
        chk("R6 off_lo clamp min", wr_off_lo, DT_MIN);
        // R7: light-load floor on the turn-on curve
        rd_on_lo = 8'd45; rd_on_hi = 8'd44; rd_off_lo = 8'd30; rd_off_hi = 8'd30;
        lim_on_idx = 3'd3; lim_on_floor = 8'd40;
        run_win(1, 8, 1000, 2000, 0, 0);
        chk("R7 on_lo floor", wr_on_lo, 40);
        chk("R7 on_hi floor", wr_on_hi, 40);
        run_win(3, 8, 1000, 2000, 0, 0);
        chk("R7 no floor at idx 3", int'(wr_on_lo) < 40, 1);
        // R1: reset mid-window then a clean window
        run_win(0, 3, 600, 100, 0, 0);
        @(negedge clk); s_vld = 1'b1; loss = 12'd77;
        @(negedge clk); s_vld = 1'b0; rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dith after reset", {dith_on, dith_off}, 3);
        lim_on_idx = '0;
        run_win(5, 11, 700, 120, -60, 0);
        chk("R4 writes seen", n_wr, 10);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule